// File: doc/BRIEF.md
# Load Queue with Store-Ordering Check

This block keeps track of the loads that an out-of-order core has in flight, in program order. Each load enters the ring with a sequence number and gets a slot index back. When the load executes, its address is written into its slot. When a store executes, the block looks at every load that entered after that store and reports, in the same cycle, whether one of them already read the same address block. Such a load read ahead of the store and got a stale value.

The first such load is held in a violator register until the pipeline takes it. Loads leave from the oldest end when commit moves past their sequence number. On a flush they are removed from the youngest end, down to the flush point. A small blocked-load record is also kept, and a flush that reaches back past the blocked load clears it.

The ring has one more slot than the number of loads it may hold. This keeps an empty ring and a full ring apart using only the two pointers.

Top module: `lq_ordering_queue`

## Requirements
- R1: The ring has LQ_DEPTH+1 slots and holds at most LQ_DEPTH loads. `lq_full` is high exactly when the slot after the tail, modulo LQ_DEPTH+1, is the head. An insert while full is ignored, and `occupancy` is unchanged by it.
- R2: `ins_lq_idx` always shows the current tail slot. An accepted insert writes its sequence number at that slot and moves the tail on by one. In the same cycle, `ins_sq_ref` is all ones when `stq_empty` is high; otherwise it is `stq_tail` with a zero top bit.
- R3: A store check scans from slot `st_lq_idx` up to, but not including, the tail. A load conflicts when its recorded address and `st_addr` are equal once the low BLK_SHIFT bits of both are dropped. A load whose address has not been written since its insert never conflicts. `st_conflict` reports the result in the same cycle.
- R4: If several loads conflict, the first one met from the scan start wins. Its slot and sequence number are latched in `viol_idx` and `viol_seq`, and `viol_valid` is set. While `viol_valid` is high, store checks do not scan: `st_conflict` stays low and the latch is unchanged.
- R5: `viol_take` clears `viol_valid` on the next edge. A check in that same cycle is judged against the latch state before the take.
- R6: Commit removes loads from the head, oldest first, while the ring is not empty and the head load's sequence number is at most `cm_seq`. A request may retire any number of loads.
- R7: A flush walks back from the youngest load and removes every load whose sequence number is greater than `flush_seq`. It stops at the first load that is not younger, or when the ring is empty. The tail moves back to match.
- R8: `blk_set` records a blocked load's sequence number and sets `blk_active`. `blk_mark` sets `blk_handled` while the record is active. A flush with `flush_seq` below the recorded number clears both flags.
- R9: A flush takes priority: a commit or an insert in the same cycle is ignored, and `ins_accept` is low.
- R10: Slot indices wrap from LQ_DEPTH back to 0. This applies to inserts, retirement and store scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert a load this cycle |
| ins_seq | input | SEQ_W | Sequence number of the inserted load |
| stq_empty | input | 1 | Store queue currently holds no stores |
| stq_tail | input | SQ_IDX_W | Current store-queue tail slot |
| ins_accept | output | 1 | Insert is taken this cycle |
| ins_lq_idx | output | IDX_W | Current tail slot, given to the inserted load |
| ins_sq_ref | output | SQ_IDX_W+1 | Store position for the inserted load; all ones means none |
| exe_valid | input | 1 | A load has computed its address |
| exe_idx | input | IDX_W | Slot of the executed load |
| exe_addr | input | ADDR_W | Address of the executed load |
| st_valid | input | 1 | A store executes; request an ordering check |
| st_lq_idx | input | IDX_W | Load slot recorded with the store (scan start) |
| st_addr | input | ADDR_W | Store address |
| st_conflict | output | 1 | The check found a younger load in the same block |
| viol_take | input | 1 | Read the violator and clear the latch |
| viol_valid | output | 1 | A violator is latched |
| viol_idx | output | IDX_W | Slot of the latched violator |
| viol_seq | output | SEQ_W | Sequence number of the latched violator |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Youngest committed sequence number |
| flush_valid | input | 1 | Flush request |
| flush_seq | input | SEQ_W | Loads younger than this are removed |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blk_mark | input | 1 | Mark the blocked load as handled |
| blk_active | output | 1 | A blocked load is recorded |
| blk_handled | output | 1 | The recorded blocked load was handled |
| occupancy | output | CNT_W | Number of loads held |
| lq_full | output | 1 | No free slot |
| lq_empty | output | 1 | No load held |

## Verification
The assertions check on every cycle:
- the latch rules for the violator: it holds while it is not taken, it clears on a take, and a conflict is only reported while no violator is latched;
- that the full flag agrees with the load count;
- that a flush never raises the count;
- that the handled flag never stands without an active record.

Only the bench scenarios can show the rest: which load wins among several conflicts, that unexecuted loads are skipped, that a commit stops exactly at the sequence boundary, that a flush stops at the right point, and that scans wrap. The bench runs these against an arithmetic model of the ring. It uses directed cases and a long pseudo-random mix of operations on a four-entry configuration.

// File: rtl/lq_pkg.sv
// Ring index helpers shared by the load-queue modules.
// Assumes both operands are already below the slot count.
package lq_pkg;

    // Advance a ring index by an offset, wrapping at slots.
    function automatic int unsigned ring_add(input int unsigned a, input int unsigned b,
                                             input int unsigned slots);
        int unsigned s;
        s = a + b;
        if (s >= slots) s = s - slots;
        return s;
    endfunction

    // Forward distance from b to a around the ring.
    function automatic int unsigned ring_sub(input int unsigned a, input int unsigned b,
                                             input int unsigned slots);
        return (a >= b) ? (a - b) : (a + slots - b);
    endfunction

endpackage

// File: rtl/lq_retire_scan.sv
// Works out how many loads a commit retires from the head and how many
// loads survive a flush walking back from the tail.
// Assumes sequence numbers rise from head to tail.
module lq_retire_scan #(
    parameter int SLOTS = 9,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 4
) (
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  logic [SEQ_W-1:0] seqs [SLOTS],
    input  logic [SEQ_W-1:0] cm_seq,
    input  logic [SEQ_W-1:0] flush_seq,
    output logic [CNT_W-1:0] retire_n,
    output logic [CNT_W-1:0] keep_n
);
    import lq_pkg::*;

    // Forward walk: count head loads whose sequence is within the commit point.
    always_comb begin
        logic stop;
        int unsigned pos;
        stop     = 1'b0;
        retire_n = '0;
        for (int k = 0; k < SLOTS - 1; k++) begin
            pos = ring_add(int'(head), k, SLOTS);
            if (!stop && k < int'(count)) begin
                if (seqs[pos] <= cm_seq) retire_n = CNT_W'(k + 1);
                else stop = 1'b1;
            end
        end
    end

    // Backward walk: drop tail loads younger than the flush point.
    always_comb begin
        logic stop;
        int unsigned pos;
        stop   = 1'b0;
        keep_n = count;
        for (int k = SLOTS - 2; k >= 0; k--) begin
            pos = ring_add(int'(head), k, SLOTS);
            if (!stop && k < int'(count)) begin
                if (seqs[pos] > flush_seq) keep_n = CNT_W'(k);
                else stop = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lq_conflict_scan.sv
// Scans loads from a start slot up to the tail for the first executed load
// whose address block equals the store's block.
// Assumes start lies between head and tail; an out-of-range start scans nothing.
module lq_conflict_scan #(
    parameter int SLOTS     = 9,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 4,
    parameter int BLK_SHIFT = 8
) (
    input  logic [IDX_W-1:0]  start,
    input  logic [IDX_W-1:0]  tail,
    input  logic [ADDR_W-1:0] addrs [SLOTS],
    input  logic              addr_ok [SLOTS],
    input  logic [ADDR_W-1:0] st_addr,
    output logic              found,
    output logic [IDX_W-1:0]  hit_idx
);
    import lq_pkg::*;

    // Walk the scan window in order and keep the first block match.
    always_comb begin
        int unsigned span;
        int unsigned pos;
        found   = 1'b0;
        hit_idx = '0;
        span    = (int'(start) < SLOTS) ? ring_sub(int'(tail), int'(start), SLOTS) : 0;
        for (int k = 0; k < SLOTS; k++) begin
            pos = ring_add(int'(start) % SLOTS, k, SLOTS);
            if (!found && k < int'(span) && addr_ok[pos] &&
                ((addrs[pos] >> BLK_SHIFT) == (st_addr >> BLK_SHIFT))) begin
                found   = 1'b1;
                hit_idx = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/lq_ordering_queue.sv
// Circular load queue with one spare slot. Holds load sequence numbers and
// addresses, checks executed stores against younger loads, retires at commit
// and trims the young end on a flush.
// Assumes loads arrive in sequence order and one request of each kind per cycle.
module lq_ordering_queue #(
    parameter  int LQ_DEPTH  = 8,
    parameter  int SEQ_W     = 16,
    parameter  int ADDR_W    = 32,
    parameter  int SQ_IDX_W  = 4,
    parameter  int BLK_SHIFT = 8,
    localparam int SLOTS     = LQ_DEPTH + 1,
    localparam int IDX_W     = $clog2(SLOTS),
    localparam int CNT_W     = $clog2(LQ_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    input  logic [SEQ_W-1:0]    ins_seq,
    input  logic                stq_empty,
    input  logic [SQ_IDX_W-1:0] stq_tail,
    output logic                ins_accept,
    output logic [IDX_W-1:0]    ins_lq_idx,
    output logic [SQ_IDX_W:0]   ins_sq_ref,
    input  logic                exe_valid,
    input  logic [IDX_W-1:0]    exe_idx,
    input  logic [ADDR_W-1:0]   exe_addr,
    input  logic                st_valid,
    input  logic [IDX_W-1:0]    st_lq_idx,
    input  logic [ADDR_W-1:0]   st_addr,
    output logic                st_conflict,
    input  logic                viol_take,
    output logic                viol_valid,
    output logic [IDX_W-1:0]    viol_idx,
    output logic [SEQ_W-1:0]    viol_seq,
    input  logic                cm_valid,
    input  logic [SEQ_W-1:0]    cm_seq,
    input  logic                flush_valid,
    input  logic [SEQ_W-1:0]    flush_seq,
    input  logic                blk_set,
    input  logic [SEQ_W-1:0]    blk_seq,
    input  logic                blk_mark,
    output logic                blk_active,
    output logic                blk_handled,
    output logic [CNT_W-1:0]    occupancy,
    output logic                lq_full,
    output logic                lq_empty
);
    import lq_pkg::*;

    logic [IDX_W-1:0]  head_q;
    logic [CNT_W-1:0]  count_q;
    logic [SEQ_W-1:0]  seq_q  [SLOTS];
    logic [ADDR_W-1:0] addr_q [SLOTS];
    logic              aok_q  [SLOTS];
    logic [IDX_W-1:0]  tail;
    logic [CNT_W-1:0]  retire_n, keep_n;
    logic              found;
    logic [IDX_W-1:0]  hit_idx;
    logic              commit_go, ins_go, blk_clear;
    logic              viol_valid_q;
    logic [IDX_W-1:0]  viol_idx_q;
    logic [SEQ_W-1:0]  viol_seq_q;
    logic              blk_active_q, blk_handled_q;
    logic [SEQ_W-1:0]  blk_seq_q;

    // Pointer view and request arbitration: a flush blocks commit and insert.
    always_comb begin
        tail       = IDX_W'(ring_add(int'(head_q), int'(count_q), SLOTS));
        lq_full    = (IDX_W'(ring_add(int'(tail), 1, SLOTS)) == head_q);
        lq_empty   = (count_q == '0);
        commit_go  = cm_valid && !flush_valid;
        ins_go     = ins_valid && !lq_full && !flush_valid;
        blk_clear  = flush_valid && blk_active_q && (flush_seq < blk_seq_q);
    end

    assign ins_accept  = ins_go;
    assign ins_lq_idx  = tail;
    assign ins_sq_ref  = stq_empty ? '1 : {1'b0, stq_tail};
    assign st_conflict = st_valid && !viol_valid_q && found;
    assign viol_valid  = viol_valid_q;
    assign viol_idx    = viol_idx_q;
    assign viol_seq    = viol_seq_q;
    assign blk_active  = blk_active_q;
    assign blk_handled = blk_handled_q;
    assign occupancy   = count_q;

    lq_retire_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_retire (
        .head(head_q), .count(count_q), .seqs(seq_q), .cm_seq(cm_seq),
        .flush_seq(flush_seq), .retire_n(retire_n), .keep_n(keep_n)
    );

    lq_conflict_scan #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
                       .BLK_SHIFT(BLK_SHIFT)) u_scan (
        .start(st_lq_idx), .tail(tail), .addrs(addr_q), .addr_ok(aok_q),
        .st_addr(st_addr), .found(found), .hit_idx(hit_idx)
    );

    // Head and count: flush trims, otherwise commit retires and insert appends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
        end else if (flush_valid) begin
            count_q <= keep_n;
        end else begin
            if (commit_go) head_q <= IDX_W'(ring_add(int'(head_q), int'(retire_n), SLOTS));
            count_q <= count_q - (commit_go ? retire_n : CNT_W'(0)) + CNT_W'(ins_go);
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Per-slot storage: address capture on execute, reset of address on insert.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seq_q[s]  <= '0;
                addr_q[s] <= '0;
                aok_q[s]  <= 1'b0;
            end else begin
                if (exe_valid && exe_idx == IDX_W'(s)) begin
                    addr_q[s] <= exe_addr;
                    aok_q[s]  <= 1'b1;
                end
                if (ins_go && tail == IDX_W'(s)) begin
                    seq_q[s] <= ins_seq;
                    aok_q[s] <= 1'b0;
                end
            end
        end
    end

    // Violator latch: set by the first conflict while clear, cleared by a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_valid_q <= 1'b0;
            viol_idx_q   <= '0;
            viol_seq_q   <= '0;
        end else begin
            if (viol_take) viol_valid_q <= 1'b0;
            if (st_valid && !viol_valid_q && found) begin
                viol_valid_q <= 1'b1;
                viol_idx_q   <= hit_idx;
                viol_seq_q   <= seq_q[hit_idx];
            end
        end
    end

    // Blocked-load record: set, mark handled, cleared by a deep enough flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_active_q  <= 1'b0;
            blk_handled_q <= 1'b0;
            blk_seq_q     <= '0;
        end else if (blk_clear) begin
            blk_active_q  <= 1'b0;
            blk_handled_q <= 1'b0;
            blk_seq_q     <= '0;
        end else if (blk_set) begin
            blk_active_q  <= 1'b1;
            blk_handled_q <= 1'b0;
            blk_seq_q     <= blk_seq;
        end else if (blk_mark && blk_active_q) begin
            blk_handled_q <= 1'b1;
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(LQ_DEPTH));
    assert_full_matches_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lq_full == (count_q == CNT_W'(LQ_DEPTH)));
    assert_conflict_only_unlatched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_conflict |-> (st_valid && !viol_valid));
    assert_conflict_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_conflict |=> viol_valid);
    assert_violator_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !viol_take) |=> (viol_valid && $stable(viol_idx) && $stable(viol_seq)));
    assert_take_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_take) |=> !viol_valid);
    assert_flush_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> occupancy <= $past(occupancy));
    assert_handled_needs_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_handled |-> blk_active);

endmodule

// File: tb/tb_lq_ordering_queue.sv
`timescale 1ns/1ps
module tb_lq_ordering_queue;
    localparam int N = 4;
    localparam int S = N + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 0, stq_empty = 0, exe_valid = 0, st_valid = 0, viol_take = 0;
    logic cm_valid = 0, flush_valid = 0, blk_set = 0, blk_mark = 0;
    logic [15:0] ins_seq = 0, cm_seq = 0, flush_seq = 0, blk_seq = 0;
    logic [2:0]  stq_tail = 0, exe_idx = 0, st_lq_idx = 0;
    logic [15:0] exe_addr = 0, st_addr = 0;
    logic        ins_accept, st_conflict, viol_valid, blk_active, blk_handled;
    logic        lq_full, lq_empty;
    logic [2:0]  ins_lq_idx, viol_idx, occupancy;
    logic [3:0]  ins_sq_ref;
    logic [15:0] viol_seq;

    always #4 clk = ~clk;

    lq_ordering_queue #(.LQ_DEPTH(N), .SEQ_W(16), .ADDR_W(16), .SQ_IDX_W(3),
                        .BLK_SHIFT(8)) dut (.*);

    int nchk = 0, nfail = 0;
    int m_seq [S], m_addr [S];
    bit m_aok [S];
    int m_head = 0, m_cnt = 0, m_vidx = 0, m_vseq = 0, m_bseq = 0, next_seq = 10;
    bit m_vv = 0, m_bact = 0, m_bhand = 0, done = 0;
    int unsigned lcg = 32'h1234_5678;

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        lcg = lcg * 1103515245 + 12345;
        return int'((lcg >> 8) % m);
    endfunction

    function automatic bit model_scan(input int start, input int a, output int hit);
        int span;
        int tl;
        int p;
        tl = (m_head + m_cnt) % S;
        span = (tl - start + S) % S;
        hit = 0;
        for (int k = 0; k < span; k++) begin
            p = (start + k) % S;
            if (m_aok[p] && (m_addr[p] >> 8) == (a >> 8)) begin
                hit = p;
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic clear_in();
        ins_valid = 0; exe_valid = 0; st_valid = 0; viol_take = 0;
        cm_valid = 0; flush_valid = 0; blk_set = 0; blk_mark = 0;
    endtask

    // One clock: check same-cycle outputs, clock, update model, check state.
    task automatic run_cycle();
        int tl, hit, p, nc;
        bit fnd, acc, cm_go;
        #1;
        tl  = (m_head + m_cnt) % S;
        acc = ins_valid && (m_cnt != N) && !flush_valid;
        fnd = st_valid && !m_vv && model_scan(int'(st_lq_idx), int'(st_addr), hit);
        chk("R3", "st_conflict", st_conflict, fnd);
        chk("R2", "ins_lq_idx", ins_lq_idx, tl);
        chk("R9", "ins_accept", ins_accept, acc);
        chk("R2", "ins_sq_ref", ins_sq_ref, stq_empty ? 15 : int'(stq_tail));
        @(posedge clk);
        cm_go = cm_valid && !flush_valid;
        if (viol_take) m_vv = 0;
        if (fnd) begin m_vv = 1; m_vidx = hit; m_vseq = m_seq[hit]; end
        if (exe_valid) begin m_addr[exe_idx] = int'(exe_addr); m_aok[exe_idx] = 1; end
        if (acc) begin m_seq[tl] = int'(ins_seq); m_aok[tl] = 0; next_seq++; end
        if (flush_valid) begin
            nc = m_cnt;
            for (int k = m_cnt - 1; k >= 0; k--) begin
                p = (m_head + k) % S;
                if (m_seq[p] > int'(flush_seq)) nc = k; else break;
            end
            m_cnt = nc;
        end else begin
            while (cm_go && m_cnt > 0 && m_seq[m_head] <= int'(cm_seq)) begin
                m_head = (m_head + 1) % S; m_cnt--;
            end
            if (acc) m_cnt++;
        end
        if (flush_valid && m_bact && int'(flush_seq) < m_bseq) begin
            m_bact = 0; m_bhand = 0; m_bseq = 0;
        end else if (blk_set) begin
            m_bact = 1; m_bhand = 0; m_bseq = int'(blk_seq);
        end else if (blk_mark && m_bact) m_bhand = 1;
        #1 clear_in();
        @(negedge clk);
        chk("R6", "occupancy", occupancy, m_cnt);
        chk("R7", "tail", ins_lq_idx, (m_head + m_cnt) % S);
        chk("R1", "lq_full", lq_full, m_cnt == N);
        chk("R1", "lq_empty", lq_empty, m_cnt == 0);
        chk("R4", "viol_valid", viol_valid, m_vv);
        if (m_vv) begin
            chk("R4", "viol_idx", viol_idx, m_vidx);
            chk("R4", "viol_seq", viol_seq, m_vseq);
        end
        chk("R8", "blk_active", blk_active, m_bact);
        chk("R8", "blk_handled", blk_handled, m_bhand);
    endtask

    task automatic do_insert(input bit se, input int st);
        ins_valid = 1; ins_seq = 16'(next_seq); stq_empty = se; stq_tail = 3'(st);
        run_cycle();
    endtask

    task automatic do_exe(input int idx, input int a);
        exe_valid = 1; exe_idx = 3'(idx); exe_addr = 16'(a);
        run_cycle();
    endtask

    task automatic do_store(input int start, input int a);
        st_valid = 1; st_lq_idx = 3'(start); st_addr = 16'(a);
        run_cycle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < S; i++) begin m_seq[i] = 0; m_addr[i] = 0; m_aok[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1", "reset occupancy", occupancy, 0);
        chk("R1", "reset empty", lq_empty, 1);
        chk("R4", "reset viol_valid", viol_valid, 0);
        chk("R8", "reset blk_active", blk_active, 0);

        // R1/R2: fill to capacity, then an extra insert is dropped.
        do_insert(1, 0);
        do_insert(0, 5);
        do_insert(1, 2);
        do_insert(0, 7);
        chk("R1", "full after N", lq_full, 1);
        ins_valid = 1; ins_seq = 16'(99);
        #1 chk("R1", "insert refused when full", ins_accept, 0);
        run_cycle();
        chk("R1", "occupancy held at N", occupancy, N);

        // R3/R4: executed loads 0..2; slot 3 never executed.
        do_exe(0, 'h0110);
        do_exe(1, 'h0220);
        do_exe(2, 'h02F0);
        st_valid = 1; st_lq_idx = 3; st_addr = 16'h0010;
        #1 chk("R3", "unexecuted load ignored", st_conflict, 0);
        run_cycle();
        do_store(1, 'h0255);
        chk("R4", "first conflict wins idx", viol_idx, 1);
        chk("R4", "first conflict wins seq", viol_seq, 11);
        st_valid = 1; st_lq_idx = 0; st_addr = 16'h0111;
        #1 chk("R4", "no scan while latched", st_conflict, 0);
        run_cycle();
        chk("R4", "latch unchanged", viol_idx, 1);
        viol_take = 1;
        run_cycle();
        chk("R5", "take clears", viol_valid, 0);

        // R6: commit up to 11 retires two.
        cm_valid = 1; cm_seq = 16'd11;
        run_cycle();
        chk("R6", "commit retired two", occupancy, 2);

        // R7/R9: flush at 12 with commit and insert in the same cycle.
        flush_valid = 1; flush_seq = 16'd12; ins_valid = 1; ins_seq = 16'(next_seq);
        cm_valid = 1; cm_seq = 16'd12;
        #1 chk("R9", "insert blocked by flush", ins_accept, 0);
        run_cycle();
        chk("R9", "commit blocked by flush", occupancy, 1);
        chk("R7", "tail moved back", ins_lq_idx, 3);

        // R10: inserts wrap into slot 0, scan wraps too.
        do_insert(1, 0);
        do_insert(1, 0);
        chk("R10", "tail wrapped to 0", ins_lq_idx, 0);
        do_insert(1, 0);
        do_exe(0, 'h0500);
        do_store(4, 'h05AA);
        chk("R10", "wrapped scan hit slot 0", viol_idx, 0);
        viol_take = 1;
        run_cycle();

        // R8: blocked record survives a shallow flush, cleared by a deep one.
        blk_set = 1; blk_seq = 16'd15;
        run_cycle();
        blk_mark = 1;
        run_cycle();
        chk("R8", "handled set", blk_handled, 1);
        flush_valid = 1; flush_seq = 16'd20;
        run_cycle();
        chk("R8", "shallow flush keeps record", blk_active, 1);
        flush_valid = 1; flush_seq = 16'd14;
        run_cycle();
        chk("R8", "deep flush clears record", blk_active, 0);
        chk("R7", "flush kept two", occupancy, 2);

        // Mixed sweep against the model.
        for (int c = 0; c < 4000; c++) begin
            ins_valid = (rnd(2) == 0); ins_seq = 16'(next_seq);
            stq_empty = (rnd(2) == 0); stq_tail = 3'(rnd(8));
            if (rnd(5) < 2) begin exe_valid = 1; exe_idx = 3'(rnd(S));
                exe_addr = 16'((rnd(4) << 8) | rnd(256)); end
            if (rnd(10) < 3) begin st_valid = 1;
                st_lq_idx = 3'((m_head + rnd(m_cnt + 1)) % S);
                st_addr = 16'((rnd(4) << 8) | rnd(256)); end
            viol_take = (rnd(5) == 0);
            if (rnd(7) == 0 && m_cnt > 0) begin cm_valid = 1;
                cm_seq = 16'(m_seq[m_head] + rnd(3)); end
            if (rnd(12) == 0) begin flush_valid = 1;
                flush_seq = 16'(next_seq - 1 - rnd(6)); end
            if (rnd(20) == 0) begin blk_set = 1; blk_seq = 16'(next_seq - rnd(4)); end
            blk_mark = (rnd(6) == 0);
            run_cycle();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule